// File: doc/BRIEF.md
# Two-Read One-Write Register Bank

This block holds the program registers of a small processor datapath. A register is chosen by a 4-bit identifier, and that identifier is the storage address with no translation. Two read ports and one write port work independently, so two operands can be fetched and one result retired in the same clock cycle.

Reads are purely combinational. A read port's data output follows its identifier after gate delay and does not wait for a clock. Writes are registered: the selected register takes the write data on the rising clock edge. The all-ones identifier (15) is reserved to mean "no register". A write aimed at it is dropped, and a read port given it returns zero. This leaves 15 real storage registers.

An active-low synchronous reset clears every register to zero. There is no internal forwarding. A read of the register that is being written in the same cycle returns the old contents until the edge.

Top module: `regbank_2r1w`

## Requirements
- R1: While `rst_n` is low at a rising edge of `clk`, all 15 registers become 0. From the next cycle on, every read port returns 0 for every identifier.
- R2: When `wr_id` is in the range 0 to 14 at a rising edge, the register numbered `wr_id` takes `wr_data`. Register n is read back by presenting identifier n.
- R3: When `wr_id` is 15 (all ones) at a rising edge, no register changes.
- R4: A read port whose identifier is 15 drives 0 on its data output.
- R5: Each read data output follows its identifier combinationally. Changing the identifier between clock edges changes the output without any clock edge.
- R6: Both read ports and the write port operate in the same cycle without interfering, and both read ports may select the same register.
- R7: A read of the register addressed by `wr_id` in the same cycle returns the value stored before the edge. The new value appears only after the rising edge.
- R8: A register that is not written keeps its value across any number of clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes and reset act on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| rd_a_id | input | 4 | Identifier for read port A (15 = none) |
| rd_a_data | output | 32 | Read port A data |
| rd_b_id | input | 4 | Identifier for read port B (15 = none) |
| rd_b_data | output | 32 | Read port B data |
| wr_id | input | 4 | Write identifier (15 = no write) |
| wr_data | input | 32 | Write data |

## Verification
The assertions check on every cycle that the reserved identifier reads as zero on both ports, and that a written register reads back its data on the next cycle. They also check that a read output holds steady when its identifier is unchanged and no write happened, and that both ports read zero right after reset. Only the bench scenarios can show the full picture of the register contents. That picture is compared against a shadow array: that a write to identifier 15 leaves all 15 registers intact, that a same-cycle read of the register being written still shows the old value before the edge, and that an identifier change between edges alters the output with no clock.

// File: rtl/regbank_pkg.sv
package regbank_pkg;
    parameter int DEF_DATA_W = 32;
    parameter int DEF_ID_W   = 4;
endpackage

// File: rtl/regbank_store.sv
module regbank_store #(
    parameter int DATA_W = 32,
    parameter int ID_W   = 4,
    parameter int NREGS  = 15
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ID_W-1:0]         wr_id,
    input  logic [DATA_W-1:0]       wr_data,
    output logic [NREGS*DATA_W-1:0] cells
);
    // One flop word per real register; the all-ones id matches none (R3).
    for (genvar g = 0; g < NREGS; g++) begin : g_cell
        logic              hit;
        logic [DATA_W-1:0] q;

        assign hit = (wr_id == ID_W'(g));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q <= '0;                      // R1
            end else if (hit) begin
                q <= wr_data;                 // R2
            end
        end

        assign cells[g*DATA_W +: DATA_W] = q;
    end
endmodule

// File: rtl/regbank_rdport.sv
module regbank_rdport #(
    parameter int DATA_W = 32,
    parameter int ID_W   = 4,
    parameter int NREGS  = 15
) (
    input  logic [NREGS*DATA_W-1:0] cells,
    input  logic [ID_W-1:0]         id,
    output logic [DATA_W-1:0]       data
);
    // Combinational select (R5); no match for the null id gives 0 (R4).
    always_comb begin
        data = '0;
        for (int i = 0; i < NREGS; i++) begin
            if (id == ID_W'(i)) begin
                data = cells[i*DATA_W +: DATA_W];
            end
        end
    end
endmodule

// File: rtl/regbank_2r1w.sv
module regbank_2r1w
    import regbank_pkg::*;
#(
    parameter int DATA_W = DEF_DATA_W,
    parameter int ID_W   = DEF_ID_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ID_W-1:0]   rd_a_id,
    output logic [DATA_W-1:0] rd_a_data,
    input  logic [ID_W-1:0]   rd_b_id,
    output logic [DATA_W-1:0] rd_b_data,
    input  logic [ID_W-1:0]   wr_id,
    input  logic [DATA_W-1:0] wr_data
);
    localparam int NREGS = (1 << ID_W) - 1;

    logic [NREGS*DATA_W-1:0] cells;

    regbank_store #(.DATA_W(DATA_W), .ID_W(ID_W), .NREGS(NREGS)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_id   (wr_id),
        .wr_data (wr_data),
        .cells   (cells)
    );

    // Two independent read ports sharing the storage (R6); no bypass (R7).
    regbank_rdport #(.DATA_W(DATA_W), .ID_W(ID_W), .NREGS(NREGS)) u_rd_a (
        .cells (cells),
        .id    (rd_a_id),
        .data  (rd_a_data)
    );

    regbank_rdport #(.DATA_W(DATA_W), .ID_W(ID_W), .NREGS(NREGS)) u_rd_b (
        .cells (cells),
        .id    (rd_b_id),
        .data  (rd_b_data)
    );
endmodule

// File: rtl/regbank_checker.sv
module regbank_checker #(
    parameter int DATA_W = 32,
    parameter int ID_W   = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ID_W-1:0]   rd_a_id,
    input logic [DATA_W-1:0] rd_a_data,
    input logic [ID_W-1:0]   rd_b_id,
    input logic [DATA_W-1:0] rd_b_data,
    input logic [ID_W-1:0]   wr_id,
    input logic [DATA_W-1:0] wr_data
);
    localparam logic [ID_W-1:0] NULL_ID = {ID_W{1'b1}};

    logic after_rst = 1'b0;
    logic seen_rst  = 1'b0;
    always_ff @(posedge clk) begin
        after_rst <= !rst_n;
        if (!rst_n) seen_rst <= 1'b1;
    end

    a_r1_zero_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        after_rst |-> (rd_a_data == '0 && rd_b_data == '0));

    a_r4_null_read_a: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_rst && rd_a_id == NULL_ID) |-> rd_a_data == '0);

    a_r4_null_read_b: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_rst && rd_b_id == NULL_ID) |-> rd_b_data == '0);

    a_r2_write_visible_a: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_rst && wr_id != NULL_ID) |=>
            (rd_a_id != $past(wr_id) || rd_a_data == $past(wr_data)));

    a_r6_write_visible_b: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_rst && wr_id != NULL_ID) |=>
            (rd_b_id != $past(wr_id) || rd_b_data == $past(wr_data)));

    a_r8_hold_a: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_rst && !after_rst && $past(wr_id) == NULL_ID && $stable(rd_a_id))
            |-> $stable(rd_a_data));
endmodule

bind regbank_2r1w regbank_checker #(.DATA_W(DATA_W), .ID_W(ID_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_a_id   (rd_a_id),
    .rd_a_data (rd_a_data),
    .rd_b_id   (rd_b_id),
    .rd_b_data (rd_b_data),
    .wr_id     (wr_id),
    .wr_data   (wr_data)
);

// File: tb/regbank_2r1w_test.sv
`timescale 1ns/1ps
module regbank_2r1w_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  rd_a_id = 4'hF;
    logic [31:0] rd_a_data;
    logic [3:0]  rd_b_id = 4'hF;
    logic [31:0] rd_b_data;
    logic [3:0]  wr_id = 4'hF;
    logic [31:0] wr_data = '0;

    int checks = 0;
    int errors = 0;
    logic [31:0] shadow [15];

    always #2 clk = ~clk;   // 250 MHz

    regbank_2r1w uut (
        .clk(clk), .rst_n(rst_n),
        .rd_a_id(rd_a_id), .rd_a_data(rd_a_data),
        .rd_b_id(rd_b_id), .rd_b_data(rd_b_data),
        .wr_id(wr_id), .wr_data(wr_data)
    );

    // Vector fields: write id, write data, read A id, read B id.
    localparam int NV = 10;
    localparam logic [43:0] VEC [NV] = '{
        {4'd3,  32'h1111_0003, 4'd3,  4'd3 },
        {4'd7,  32'hA5A5_0007, 4'd3,  4'd7 },
        {4'd3,  32'h2222_0003, 4'd3,  4'd7 },
        {4'd0,  32'hFFFF_FFFF, 4'd7,  4'd0 },
        {4'd14, 32'h0E0E_0E0E, 4'd14, 4'd15},
        {4'd15, 32'hDEAD_BEEF, 4'd14, 4'd0 },
        {4'd15, 32'h1234_5678, 4'd15, 4'd3 },
        {4'd7,  32'h0000_0001, 4'd7,  4'd7 },
        {4'd1,  32'h8000_0000, 4'd0,  4'd1 },
        {4'd1,  32'h0000_0002, 4'd1,  4'd14}
    };

    function automatic logic [31:0] expect_of(input logic [3:0] id);
        return (id == 4'hF) ? 32'h0 : shadow[id];
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive at negedge, check reads before the edge (old data), then commit.
    task automatic step(input logic [3:0] wid, input logic [31:0] wd,
                        input logic [3:0] ra, input logic [3:0] rb, input string req);
        @(negedge clk);
        wr_id = wid; wr_data = wd; rd_a_id = ra; rd_b_id = rb;
        #1;
        check(req, rd_a_data, expect_of(ra));
        check(req, rd_b_data, expect_of(rb));
        @(posedge clk);
        if (wid != 4'hF) shadow[wid] = wd;
        #1;
    endtask

    task automatic sweep(input string req);
        @(negedge clk);
        wr_id = 4'hF;
        for (int i = 0; i < 16; i++) begin
            rd_a_id = 4'(i); rd_b_id = 4'(15 - i);
            #0.1;
            check(req, rd_a_data, expect_of(4'(i)));
            check(req, rd_b_data, expect_of(4'(15 - i)));
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; wr_id = 4'hF;
        @(posedge clk); @(posedge clk);
        for (int i = 0; i < 15; i++) shadow[i] = '0;
        #1 rst_n = 1'b1;
    endtask

    initial begin
        for (int i = 0; i < 15; i++) shadow[i] = '0;
        do_reset();
        sweep("R1 reset clears");

        // Table walk: mixes R2, R6, R7 and R3 rows.
        for (int v = 0; v < NV; v++) begin
            step(VEC[v][43:40], VEC[v][39:8], VEC[v][7:4], VEC[v][3:0], "R6/R7 table");
        end
        sweep("R2 table contents");

        // R2: fill every register with a distinct value.
        for (int i = 0; i < 15; i++) begin
            step(4'(i), 32'hC0DE_0000 + 32'(i * 17), 4'(i), 4'hF, "R7 old before edge");
        end
        sweep("R2 all registers");

        // R3: writes to id 15 change nothing.
        step(4'hF, 32'hFFFF_FFFF, 4'hF, 4'd5, "R4 null read");
        step(4'hF, 32'h5555_AAAA, 4'd5, 4'hF, "R3 null write");
        sweep("R3 no register changed");

        // R7: same-cycle read of the written register shows old value, new after edge.
        @(negedge clk);
        wr_id = 4'd9; wr_data = 32'h0BAD_F00D; rd_a_id = 4'd9; rd_b_id = 4'd9;
        #1;
        check("R7 old value A", rd_a_data, shadow[9]);
        check("R7 old value B", rd_b_data, shadow[9]);
        @(posedge clk); shadow[9] = 32'h0BAD_F00D; #1;
        check("R7 new value after edge", rd_a_data, 32'h0BAD_F00D);
        wr_id = 4'hF;

        // R5: identifier change between edges alters output without a clock.
        @(negedge clk);
        rd_a_id = 4'd2; #0.5;
        check("R5 comb read", rd_a_data, shadow[2]);
        rd_a_id = 4'd11; #0.5;
        check("R5 comb read", rd_a_data, shadow[11]);

        // R8: values hold over idle cycles.
        repeat (20) @(posedge clk);
        sweep("R8 hold");

        // R1: reset after data clears everything.
        do_reset();
        sweep("R1 reset after data");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #800000;
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule